// File: doc/BRIEF.md
# Bandwidth Slot-Table Builder

This block computes the contents of a memory arbiter's slot table. The table has 64 entries and each entry names one of 14 clients. Configuration software latches three inputs and then pulses `start`. The inputs are a requested slot count for each client, a mask of active clients and a count of spare slots. The engine then walks the clients one by one and places each client's slots at an even spacing. After that it hands out leftover positions, and finally it streams the finished table to the arbiter's table write port, one entry per clock.

Placement runs in two passes. In the first pass, clients are visited from index 0 upward. A client that asked for slots is spread across the table with a fixed stride. An active client that asked for nothing may receive a single slot, but only while spare slots remain. In the second pass, every position that is still empty goes to the active clients in turn. When the stream ends, a one-cycle `done` pulse follows.

Converting a bandwidth figure into a slot count, and rejecting a request set that over-allocates the table, are tasks of the caller.

Top module: `slot_table_builder`

## Requirements
- R1: After reset, `busy`, `done` and `wrEn` are low. A `start` pulse seen while idle makes `busy` high on the next cycle.
- R2: Clients are placed in ascending index order. A client with request r (1 to 64) uses stride floor(64/r). A cursor starts at position 0. Landing on an occupied position advances the cursor by 1. Landing on an empty position writes the client there and advances the cursor by the stride. Placement ends once the cursor reaches 64.
- R3: An active client with a request of 0 receives one slot, at the first empty position, if the spare count is above zero. Each such grant lowers the spare count by one. Once the count reaches zero, such clients receive nothing in the first pass.
- R4: An inactive client with a request of 0 is skipped in the first pass, whatever the spare count.
- R5: In the second pass, positions still empty are taken in ascending order. Each one is given to the first active client found, scanning circularly from a pointer that starts at client 0. After each fill, the pointer moves to one past the client just assigned.
- R6: If no client is active, each empty position in the second pass receives the pointer's current client. The pointer then advances by one, modulo 14.
- R7: The finished table leaves as 64 consecutive `wrEn` cycles with `wrIdx` 0, 1, ..., 63. Every `wrData` value lies in 0 to 13, so no empty marker remains.
- R8: `done` is high for exactly one cycle. That cycle follows the write of index 63, and `busy` is low on the cycle after `done`.
- R9: A `start` pulse, or a change of the configuration inputs, while `busy` is high has no effect on the table produced. It also does not launch a second run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a build; taken only while idle |
| reqSlots | input | 98 | Requested slot count per client, 7 bits each, client c at bits [7c+6:7c], meaningful range 0 to 64 |
| activeMask | input | 14 | Bit c high marks client c as active |
| unusedSlots | input | 7 | Spare slots available for zero-request clients |
| busy | output | 1 | High from the cycle after an accepted start through the `done` cycle |
| done | output | 1 | One-cycle completion pulse |
| wrEn | output | 1 | Table write strobe |
| wrIdx | output | 6 | Table entry being written |
| wrData | output | 4 | Client number for that entry |

## Verification
The situations hardest to reach from the ports are two. The first is the second-pass scan finding no active client at all. The second is a request set in which stride cursors run into positions already claimed by lower clients, so that first-free skipping shifts the later placements. Directed cases cover an all-inactive table and stacked strides such as 2, 4 and 21 that collide. About thirty pseudo-random configurations then mix requests, activity and spare counts, and every streamed entry is compared against a table rebuilt in the bench from the requirements. One run also scrambles the inputs and pulses `start` mid-build, to show that the latched configuration alone decides the result.

// File: rtl/slot_table_pkg.sv
package slot_table_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic init;        // latch configuration, empty the table
    logic beginPlace;  // load stride for current client, rewind cursor
    logic nextClient;  // advance client index
    logic stepPos;     // cursor hit an occupied cell: move by one
    logic placeCell;   // write current client at cursor, move by stride
    logic fillSlot;    // second pass: write round-robin pick at slot index
    logic slotInc;     // advance slot index
    logic clearSlot;   // rewind slot index
  } ctl_strobe_t;

  // Conditions reported back by the datapath.
  typedef struct packed {
    logic curHasReq;
    logic curActive;
    logic haveUnused;
    logic posEnd;
    logic cellFull;
    logic lastClient;
    logic slotFull;
    logic lastSlot;
  } dp_status_t;

endpackage

// File: rtl/slot_table_dp.sv
module slot_table_dp
  import slot_table_pkg::*;
#(
  parameter int NUM_CLIENTS = 14,
  parameter int NUM_SLOTS   = 64,
  localparam int CLIENT_W = $clog2(NUM_CLIENTS + 1),
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int POS_W    = SLOT_W + 1,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctl_strobe_t                  ctl,
  input  logic [NUM_CLIENTS*CNT_W-1:0] reqIn,
  input  logic [NUM_CLIENTS-1:0]       actIn,
  input  logic [CNT_W-1:0]             unusedIn,
  output dp_status_t                   stat,
  output logic [SLOT_W-1:0]            wrIdx,
  output logic [CLIENT_W-1:0]          wrData
);

  // All-ones code is never a client index, so it marks an empty cell.
  localparam logic [CLIENT_W-1:0] EMPTY = '1;

  logic [CLIENT_W-1:0] tbl [NUM_SLOTS];
  logic [CNT_W-1:0]    reqLat [NUM_CLIENTS];
  logic [NUM_CLIENTS-1:0] actLat;
  logic [CNT_W-1:0]    unusedCnt;
  logic [CLIENT_W-1:0] clientIdx;
  logic [CLIENT_W-1:0] rrPtr;
  logic [CLIENT_W-1:0] rrPick;
  logic [CLIENT_W-1:0] rrNext;
  logic                rrFound;
  logic [POS_W-1:0]    pos;
  logic [POS_W-1:0]    stride;
  logic [POS_W-1:0]    strideNext;
  logic [SLOT_W-1:0]   slotIdx;
  logic [CNT_W-1:0]    curReq;

  assign curReq = reqLat[clientIdx];

  // Stride: floor(slots / request); zero request uses the full table span,
  // an out-of-range request is clamped to stride one.
  always_comb begin
    int divisor;
    int quot;
    divisor = (curReq == '0) ? 1 : int'(curReq);
    quot    = NUM_SLOTS / divisor;
    if (quot < 1) quot = 1;
    strideNext = POS_W'(quot);
  end

  // Circular search for the first active client at or after the pointer.
  always_comb begin
    rrPick  = rrPtr;
    rrFound = 1'b0;
    for (int k = 0; k < NUM_CLIENTS; k++) begin
      int idx;
      idx = (int'(rrPtr) + k) % NUM_CLIENTS;
      if (!rrFound && actLat[idx]) begin
        rrPick  = CLIENT_W'(idx);
        rrFound = 1'b1;
      end
    end
  end

  assign rrNext = (rrPick == CLIENT_W'(NUM_CLIENTS - 1)) ? '0 : rrPick + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) tbl[s] <= EMPTY;
      for (int c = 0; c < NUM_CLIENTS; c++) reqLat[c] <= '0;
      actLat    <= '0;
      unusedCnt <= '0;
      clientIdx <= '0;
      rrPtr     <= '0;
      pos       <= '0;
      stride    <= '0;
      slotIdx   <= '0;
    end else begin
      if (ctl.init) begin
        for (int s = 0; s < NUM_SLOTS; s++) tbl[s] <= EMPTY;
        for (int c = 0; c < NUM_CLIENTS; c++) reqLat[c] <= reqIn[c*CNT_W +: CNT_W];
        actLat    <= actIn;
        unusedCnt <= unusedIn;
        clientIdx <= '0;
        rrPtr     <= '0;
        pos       <= '0;
      end
      if (ctl.beginPlace) begin
        pos    <= '0;
        stride <= strideNext;
        if (curReq == '0) unusedCnt <= unusedCnt - 1'b1;
      end
      if (ctl.nextClient) clientIdx <= clientIdx + 1'b1;
      if (ctl.stepPos) pos <= pos + 1'b1;
      if (ctl.placeCell) begin
        tbl[pos[SLOT_W-1:0]] <= clientIdx;
        pos <= pos + stride;
      end
      if (ctl.fillSlot) begin
        tbl[slotIdx] <= rrPick;
        rrPtr        <= rrNext;
      end
      if (ctl.clearSlot)    slotIdx <= '0;
      else if (ctl.slotInc) slotIdx <= slotIdx + 1'b1;
    end
  end

  always_comb begin
    stat.curHasReq  = (curReq != '0);
    stat.curActive  = actLat[clientIdx];
    stat.haveUnused = (unusedCnt != '0);
    stat.posEnd     = (pos >= POS_W'(NUM_SLOTS));
    stat.cellFull   = (tbl[pos[SLOT_W-1:0]] != EMPTY);
    stat.lastClient = (clientIdx == CLIENT_W'(NUM_CLIENTS - 1));
    stat.slotFull   = (tbl[slotIdx] != EMPTY);
    stat.lastSlot   = (slotIdx == SLOT_W'(NUM_SLOTS - 1));
  end

  assign wrIdx  = slotIdx;
  assign wrData = tbl[slotIdx];

endmodule

// File: rtl/slot_table_ctl.sv
module slot_table_ctl
  import slot_table_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dp_status_t  stat,
  output ctl_strobe_t ctl,
  output logic        busy,
  output logic        done,
  output logic        wrEn
);

  typedef enum logic [2:0] {
    S_IDLE, S_PICK, S_PLACE, S_FILL, S_STREAM, S_DONE
  } state_t;

  state_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    ctl  = '0;
    nxt  = state;
    wrEn = 1'b0;
    done = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctl.init = 1'b1;
          nxt      = S_PICK;
        end
      end
      S_PICK: begin
        if (stat.curHasReq || (stat.curActive && stat.haveUnused)) begin
          ctl.beginPlace = 1'b1;
          nxt            = S_PLACE;
        end else if (stat.lastClient) begin
          ctl.clearSlot = 1'b1;
          nxt           = S_FILL;
        end else begin
          ctl.nextClient = 1'b1;
        end
      end
      S_PLACE: begin
        if (stat.posEnd) begin
          if (stat.lastClient) begin
            ctl.clearSlot = 1'b1;
            nxt           = S_FILL;
          end else begin
            ctl.nextClient = 1'b1;
            nxt            = S_PICK;
          end
        end else if (stat.cellFull) begin
          ctl.stepPos = 1'b1;
        end else begin
          ctl.placeCell = 1'b1;
        end
      end
      S_FILL: begin
        ctl.fillSlot = !stat.slotFull;
        if (stat.lastSlot) begin
          ctl.clearSlot = 1'b1;
          nxt           = S_STREAM;
        end else begin
          ctl.slotInc = 1'b1;
        end
      end
      S_STREAM: begin
        wrEn = 1'b1;
        if (stat.lastSlot) begin
          ctl.clearSlot = 1'b1;
          nxt           = S_DONE;
        end else begin
          ctl.slotInc = 1'b1;
        end
      end
      S_DONE: begin
        done = 1'b1;
        nxt  = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/slot_table_builder.sv
module slot_table_builder
  import slot_table_pkg::*;
#(
  parameter int NUM_CLIENTS = 14,
  parameter int NUM_SLOTS   = 64,
  localparam int CLIENT_W = $clog2(NUM_CLIENTS + 1),
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [NUM_CLIENTS*CNT_W-1:0] reqSlots,
  input  logic [NUM_CLIENTS-1:0]       activeMask,
  input  logic [CNT_W-1:0]             unusedSlots,
  output logic                         busy,
  output logic                         done,
  output logic                         wrEn,
  output logic [SLOT_W-1:0]            wrIdx,
  output logic [CLIENT_W-1:0]          wrData
);

  ctl_strobe_t ctl;
  dp_status_t  stat;

  slot_table_ctl i_ctl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done),
    .wrEn  (wrEn)
  );

  slot_table_dp #(
    .NUM_CLIENTS (NUM_CLIENTS),
    .NUM_SLOTS   (NUM_SLOTS)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqIn    (reqSlots),
    .actIn    (activeMask),
    .unusedIn (unusedSlots),
    .stat     (stat),
    .wrIdx    (wrIdx),
    .wrData   (wrData)
  );

endmodule

// File: rtl/slot_table_checker.sv
module slot_table_checker #(
  parameter int NUM_CLIENTS = 14,
  parameter int NUM_SLOTS   = 64,
  localparam int CLIENT_W = $clog2(NUM_CLIENTS + 1),
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                wrEn,
  input logic [SLOT_W-1:0]   wrIdx,
  input logic [CLIENT_W-1:0] wrData
);

  localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(NUM_SLOTS - 1);

  assert_start_launch_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  assert_write_in_run_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busy);

  assert_write_client_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrData < CLIENT_W'(NUM_CLIENTS)));

  assert_write_order_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx != LAST_IDX) |=> (wrEn && wrIdx == $past(wrIdx) + SLOT_W'(1)));

  assert_last_then_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == LAST_IDX) |=> done);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_then_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

bind slot_table_builder slot_table_checker #(
  .NUM_CLIENTS (NUM_CLIENTS),
  .NUM_SLOTS   (NUM_SLOTS)
) i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .wrEn   (wrEn),
  .wrIdx  (wrIdx),
  .wrData (wrData)
);

// File: tb/test_slot_table_builder.sv
module test_slot_table_builder;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 14;
  localparam int NS = 64;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [NC*CW-1:0] reqSlots = '0;
  logic [NC-1:0] activeMask = '0;
  logic [CW-1:0] unusedSlots = '0;
  logic          busy, done, wrEn;
  logic [5:0]    wrIdx;
  logic [3:0]    wrData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int reqA [NC];
  bit actA [NC];
  int unusedA;
  int expT [NS];
  int got  [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_table_builder i_slot_table_builder (
    .clk(clk), .rstN(rstN), .start(start), .reqSlots(reqSlots),
    .activeMask(activeMask), .unusedSlots(unusedSlots),
    .busy(busy), .done(done), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected table built straight from the requirement text.
  function automatic void buildExpected();
    int t [NS];
    int spare;
    int rr;
    spare = unusedA;
    for (int s = 0; s < NS; s++) t[s] = -1;
    for (int c = 0; c < NC; c++) begin
      int step;
      int p;
      if (reqA[c] == 0) begin
        if (!actA[c] || spare <= 0) continue;
        spare--;
        step = NS;
      end else begin
        step = NS / reqA[c];
      end
      p = 0;
      while (p < NS) begin
        if (t[p] >= 0) p++;
        else begin
          t[p] = c;
          p += step;
        end
      end
    end
    rr = 0;
    for (int s = 0; s < NS; s++) begin
      if (t[s] < 0) begin
        int first;
        first = rr;
        while (!actA[rr]) begin
          rr = (rr + 1) % NC;
          if (rr == first) break;
        end
        t[s] = rr;
        rr = (rr + 1) % NC;
      end
    end
    for (int s = 0; s < NS; s++) expT[s] = t[s];
  endfunction

  task automatic driveInputs();
    for (int c = 0; c < NC; c++) begin
      reqSlots[c*CW +: CW] = CW'(reqA[c]);
      activeMask[c]        = actA[c];
    end
    unusedSlots = CW'(unusedA);
  endtask

  task automatic runCase(input string tag, input bit disturb);
    int nextIdx;
    int writes;
    int cyc;
    bit seenDone;
    bit prevLast;
    buildExpected();
    for (int s = 0; s < NS; s++) got[s] = -1;
    @(negedge clk);
    driveInputs();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    nextIdx = 0; writes = 0; cyc = 0; seenDone = 0; prevLast = 0;
    while (!seenDone && cyc < 6000) begin
      if (disturb && cyc == 3) begin
        // R9: new inputs and a start pulse while busy
        reqSlots    = {NC*CW{1'b1}};
        activeMask  = '1;
        unusedSlots = '1;
        start       = 1'b1;
      end
      if (disturb && cyc == 4) start = 1'b0;
      if (wrEn) begin
        check(int'(wrIdx) == nextIdx, "R7 write index order", int'(wrIdx), nextIdx);
        got[wrIdx] = int'(wrData);
        nextIdx++;
        writes++;
      end
      if (done) begin
        seenDone = 1;
        check(writes == NS, "R7 write count before done", writes, NS);
        check(prevLast, "R8 done follows last write", int'(prevLast), 1);
      end
      prevLast = wrEn && (wrIdx == 6'd63);
      if (!seenDone) begin
        @(negedge clk);
        cyc++;
      end
    end
    check(seenDone, {"R8 run completes ", tag}, int'(seenDone), 1);
    @(negedge clk);
    check(done == 1'b0, "R8 done single cycle", int'(done), 0);
    check(busy == 1'b0, "R8 idle after done", int'(busy), 0);
    for (int s = 0; s < NS; s++)
      check(got[s] == expT[s], {tag, " table entry"}, got[s], expT[s]);
    if (disturb) begin
      bit relaunched;
      relaunched = 0;
      repeat (6) begin
        @(negedge clk);
        if (busy || wrEn || done) relaunched = 1;
      end
      check(!relaunched, "R9 no second run", int'(relaunched), 0);
    end
  endtask

  task automatic clearCfg();
    for (int c = 0; c < NC; c++) begin
      reqA[c] = 0;
      actA[c] = 0;
    end
    unusedA = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    check(done == 1'b0, "R1 reset done", int'(done), 0);
    check(wrEn == 1'b0, "R1 reset wrEn", int'(wrEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 idle without start", int'(busy), 0);

    // R6: nobody active, every cell comes from the pointer.
    clearCfg();
    unusedA = 64;
    runCase("R6 no active clients", 0);

    // R3: every client active with zero request, plenty of spare.
    clearCfg();
    for (int c = 0; c < NC; c++) actA[c] = 1;
    unusedA = 64;
    runCase("R3 spare grants", 0);

    // R3: spare count runs out after three grants.
    unusedA = 3;
    runCase("R3 spare exhausted", 0);

    // R5: only the round-robin pass fills the table.
    clearCfg();
    actA[1] = 1; actA[4] = 1; actA[7] = 1;
    runCase("R5 round robin", 0);

    // R2: colliding strides 2, 4 and 21 plus a single slot.
    clearCfg();
    reqA[0] = 32; reqA[1] = 16; reqA[2] = 3; reqA[5] = 1;
    actA[0] = 1; actA[1] = 1; actA[2] = 1; actA[5] = 1; actA[9] = 1;
    unusedA = 10;
    runCase("R2 stride collisions", 0);

    // R9: same configuration, disturbed mid-run.
    runCase("R9 start while busy", 1);

    // R4: inactive zero-request clients get nothing despite spare slots.
    clearCfg();
    actA[2] = 1; actA[9] = 1;
    reqA[3] = 4; actA[3] = 1;
    unusedA = 64;
    runCase("R4 inactive skipped", 0);

    // R2: a full-table request.
    clearCfg();
    reqA[3] = 64; actA[3] = 1; actA[0] = 1;
    unusedA = 5;
    runCase("R2 full request", 0);

    // Mixed sweep over pseudo-random configurations.
    for (int n = 0; n < 30; n++) begin
      int total;
      clearCfg();
      total = 0;
      for (int c = 0; c < NC; c++) begin
        actA[c] = ($urandom % 2) == 1;
        if (($urandom % 3) == 0 && total < NS) begin
          reqA[c] = 1 + int'($urandom % 8);
          if (($urandom % 10) == 0) reqA[c] = 32;
          total += reqA[c];
          actA[c] = 1;
        end
      end
      unusedA = int'($urandom % 20);
      runCase("R2 R3 R4 R5 sweep", 0);
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule